// File: doc/BRIEF.md
# Serial Engine Run-State Controller

This block owns the operating state of a serial engine: held idle with its queues emptied (RESET), moving data (RUN), or stopped with its contents kept (PAUSE). Software asks for a state with a write to a state-request port. It reads back a 2-bit state field and a separate valid bit. A request that is accepted does not take effect at once. The valid bit drops for a fixed settling window, and the new state appears in the same cycle that valid returns. Software polls until valid is high and the field shows the state it asked for.

A separate software-reset write and a transfer-error input both send the core back to RESET. Leaving PAUSE for RESET through the request port is deliberately awkward: it takes two successive writes of a dedicated exit code. The block drives the enables for the serial engine and its FIFOs. It also gives a one-cycle pulse that flushes the FIFOs and clears the error flags whenever RESET is entered.

Top module: `run_state_ctrl`

## Requirements
- R1: In the first cycle after the synchronous reset `rst` is released, `rd_state` reads RESET and `rd_valid` is 1, and `eng_en`, `fifo_en`, `fifo_flush` and `err_clr` are all 0.
- R2: `rd_state` encodes RESET as 2'b00, RUN as 2'b01 and PAUSE as 2'b11, and never shows 2'b10.
- R3: A request on `st_wr` is accepted only when `rd_valid` is 1 and the 3-bit `st_code` is at most 3. A request with `st_code[2]`=1, or one made while `rd_valid` is 0, leaves `rd_state` and `rd_valid` unchanged.
- R4: The following codes start a transition to the named state when accepted: 3'b001 to RUN, 3'b011 to PAUSE, and 3'b000 to RESET (the last only outside PAUSE). After the accepting edge, `rd_valid` is 0 for exactly TRANS_CYC (default 4) cycles, and `rd_state` keeps its old value during that window. In the next cycle `rd_valid` is 1 and `rd_state` shows the target.
- R5: In PAUSE, the exit code 3'b010 only arms the exit, with no visible change. A second accepted 3'b010 with no other accepted request in between starts a transition to RESET. Any other accepted request cancels the armed exit. Code 3'b010 outside PAUSE, and code 3'b000 in PAUSE, are ignored.
- R6: `swrst_wr` with `swrst_bit`=1 starts a transition to RESET from any state, even inside a running window, where it restarts the window. With `swrst_bit`=0 it is ignored. It takes priority over `st_wr` in the same cycle.
- R7: `xfer_err` starts a transition to RESET when `rd_valid` is 1 and the state is RUN or PAUSE. It is ignored in RESET.
- R8: `eng_en` is 1 exactly when the state is RUN and `rd_valid` is 1. `fifo_en` is 1 exactly when the state is RUN or PAUSE and `rd_valid` is 1.
- R9: `fifo_flush` and `err_clr` pulse high for one cycle, which is the first cycle with `rd_valid` high after a transition into RESET completes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| st_wr | input | 1 | State-request write strobe |
| st_code | input | 3 | Requested state code |
| swrst_wr | input | 1 | Software-reset register write strobe |
| swrst_bit | input | 1 | Data bit written to the software-reset register |
| xfer_err | input | 1 | Transfer error reported by the serial engine |
| rd_state | output | 2 | Current state field |
| rd_valid | output | 1 | State-valid bit, low while a transition settles |
| eng_en | output | 1 | Serial engine enable |
| fifo_en | output | 1 | FIFO enable |
| fifo_flush | output | 1 | FIFO flush pulse on entry to RESET |
| err_clr | output | 1 | Error-flag clear pulse on entry to RESET |

## Verification
The bench attacks the exit from PAUSE from three sides:
- A single exit code: a design that treats this as a full request would fall to RESET early.
- A pending exit cancelled by an intervening PAUSE request: a design that forgets to disarm would reset on the next lone exit code.
- The exit code issued from RUN: a design that accepts it there would leave RUN.

It also checks the settling window:
- Its exact length, where an off-by-one counter shifts the cycle in which valid and the new state appear.
- A request made during the window, which a design that does not gate on valid would honour.
- A software reset made during the window, which must restart the window rather than complete the old target.

Out-of-range codes, an error in RESET, the priority of software reset over a request, and the flush pulse, which must appear once and only on entry to RESET, are checked as well.

// File: rtl/run_state_pkg.sv
package run_state_pkg;

    typedef enum logic [1:0] {
        RSC_RESET = 2'b00,
        RSC_RUN   = 2'b01,
        RSC_PAUSE = 2'b11
    } rsc_state_e;

    localparam logic [1:0] RSC_EXIT_CODE = 2'b10;

    typedef struct packed {
        logic       go;
        rsc_state_e tgt;
    } rsc_req_t;

    // Codes above the PAUSE code are outside the accepted range.
    function automatic logic code_in_range(input logic [2:0] code);
        return code <= 3'(RSC_PAUSE);
    endfunction

endpackage

// File: rtl/rsc_req_decode.sv
module rsc_req_decode
    import run_state_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       st_wr,
    input  logic [2:0] st_code,
    input  logic       swrst_wr,
    input  logic       swrst_bit,
    input  logic       xfer_err,
    input  rsc_state_e cur_state,
    input  logic       cur_valid,
    output rsc_req_t   req
);

    logic accepted;
    logic armed_q;
    logic arm_set;
    logic arm_clr;

    assign accepted = st_wr && cur_valid && code_in_range(st_code);

    always_comb begin
        req     = '{go: 1'b0, tgt: RSC_RESET};
        arm_set = 1'b0;
        arm_clr = 1'b0;
        if (swrst_wr && swrst_bit) begin
            req.go  = 1'b1;
            arm_clr = 1'b1;
        end else if (xfer_err && cur_valid && cur_state != RSC_RESET) begin
            req.go  = 1'b1;
            arm_clr = 1'b1;
        end else if (accepted) begin
            arm_clr = 1'b1;
            unique case (st_code[1:0])
                2'b00: req.go = (cur_state != RSC_PAUSE);
                2'b01: begin
                    req.go  = 1'b1;
                    req.tgt = RSC_RUN;
                end
                2'b11: begin
                    req.go  = 1'b1;
                    req.tgt = RSC_PAUSE;
                end
                default: begin
                    if (cur_state == RSC_PAUSE) begin
                        if (armed_q) begin
                            req.go = 1'b1;
                        end else begin
                            arm_set = 1'b1;
                            arm_clr = 1'b0;
                        end
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            armed_q <= 1'b0;
        end else if (arm_set) begin
            armed_q <= 1'b1;
        end else if (arm_clr) begin
            armed_q <= 1'b0;
        end
    end

    // R5: a pending exit exists only while settled in PAUSE
    a_r5_arm_only_in_pause: assert property (@(posedge clk) disable iff (rst)
        armed_q |-> (cur_state == RSC_PAUSE && cur_valid));

endmodule

// File: rtl/rsc_trans_timer.sv
module rsc_trans_timer
    import run_state_pkg::*;
#(
    parameter int TRANS_CYC = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  rsc_req_t   req,
    output logic       busy,
    output logic       done,
    output rsc_state_e tgt
);

    localparam int CNT_W = $clog2(TRANS_CYC + 1);

    logic [CNT_W-1:0] cnt_q;
    logic             busy_q;
    rsc_state_e       tgt_q;

    assign busy = busy_q;
    assign tgt  = tgt_q;
    assign done = busy_q && (cnt_q == '0) && !req.go;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            cnt_q  <= '0;
            tgt_q  <= RSC_RESET;
        end else if (req.go) begin
            busy_q <= 1'b1;
            cnt_q  <= CNT_W'(TRANS_CYC - 1);
            tgt_q  <= req.tgt;
        end else if (busy_q) begin
            if (cnt_q == '0) begin
                busy_q <= 1'b0;
            end else begin
                cnt_q <= cnt_q - 1'b1;
            end
        end
    end

    // R4: the window counter never exceeds its load value
    a_r4_count_bound: assert property (@(posedge clk) disable iff (rst)
        busy_q |-> (cnt_q <= CNT_W'(TRANS_CYC - 1)));

    // R4: a window with cycles left to run stays open
    a_r4_window_holds: assert property (@(posedge clk) disable iff (rst)
        (busy_q && cnt_q != '0) |=> busy_q);

endmodule

// File: rtl/run_state_ctrl.sv
module run_state_ctrl
    import run_state_pkg::*;
#(
    parameter int TRANS_CYC = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       st_wr,
    input  logic [2:0] st_code,
    input  logic       swrst_wr,
    input  logic       swrst_bit,
    input  logic       xfer_err,
    output logic [1:0] rd_state,
    output logic       rd_valid,
    output logic       eng_en,
    output logic       fifo_en,
    output logic       fifo_flush,
    output logic       err_clr
);

    rsc_state_e state_q;
    rsc_req_t   req;
    logic       busy;
    logic       done;
    rsc_state_e tgt;
    logic       flush_q;

    rsc_req_decode u_dec (
        .clk       (clk),
        .rst       (rst),
        .st_wr     (st_wr),
        .st_code   (st_code),
        .swrst_wr  (swrst_wr),
        .swrst_bit (swrst_bit),
        .xfer_err  (xfer_err),
        .cur_state (state_q),
        .cur_valid (!busy),
        .req       (req)
    );

    rsc_trans_timer #(.TRANS_CYC(TRANS_CYC)) u_tmr (
        .clk  (clk),
        .rst  (rst),
        .req  (req),
        .busy (busy),
        .done (done),
        .tgt  (tgt)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= RSC_RESET;
            flush_q <= 1'b0;
        end else begin
            flush_q <= done && (tgt == RSC_RESET);
            if (done) begin
                state_q <= tgt;
            end
        end
    end

    assign rd_state   = state_q;
    assign rd_valid   = !busy;
    assign eng_en     = !busy && (state_q == RSC_RUN);
    assign fifo_en    = !busy && (state_q != RSC_RESET);
    assign fifo_flush = flush_q;
    assign err_clr    = flush_q;

    // R2: the unused encoding never appears
    a_r2_legal_state: assert property (@(posedge clk) disable iff (rst)
        rd_state != 2'b10);

    // R4: the state field does not move while valid is low
    a_r4_state_frozen: assert property (@(posedge clk) disable iff (rst)
        !rd_valid |=> (rd_valid || $stable(rd_state)));

    // R3: an out-of-range request with nothing else pending keeps valid high
    a_r3_bad_code_ignored: assert property (@(posedge clk) disable iff (rst)
        (rd_valid && st_wr && st_code[2] && !swrst_wr && !xfer_err) |=> rd_valid);

    // R9: the flush pulse marks the first valid cycle in RESET
    a_r9_flush_on_entry: assert property (@(posedge clk) disable iff (rst)
        fifo_flush |-> (rd_state == 2'b00 && rd_valid && !$past(rd_valid)));

endmodule

// File: tb/sim_run_state_ctrl.sv
module sim_run_state_ctrl;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       st_wr = 1'b0;
    logic [2:0] st_code = 3'b000;
    logic       swrst_wr = 1'b0;
    logic       swrst_bit = 1'b0;
    logic       xfer_err = 1'b0;
    logic [1:0] rd_state;
    logic       rd_valid;
    logic       eng_en;
    logic       fifo_en;
    logic       fifo_flush;
    logic       err_clr;

    localparam logic [1:0] S_RST = 2'b00, S_RUN = 2'b01, S_PAU = 2'b11;

    typedef struct {
        int         cyc;
        logic [1:0] st;
        logic       v;
        logic       fl;
        string      req;
    } exp_t;

    exp_t q[$];
    int   cyc = 0;
    int   n_cmp = 0;
    int   n_bad = 0;
    bit   done_flag = 1'b0;

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    run_state_ctrl u0 (
        .clk(clk), .rst(rst), .st_wr(st_wr), .st_code(st_code),
        .swrst_wr(swrst_wr), .swrst_bit(swrst_bit), .xfer_err(xfer_err),
        .rd_state(rd_state), .rd_valid(rd_valid), .eng_en(eng_en),
        .fifo_en(fifo_en), .fifo_flush(fifo_flush), .err_clr(err_clr)
    );

    // monitor: pop items due this cycle and compare
    always @(negedge clk) begin
        while (q.size() > 0 && q[0].cyc <= cyc) begin
            exp_t e;
            logic xe;
            logic xf;
            e  = q.pop_front();
            xe = e.v && (e.st == S_RUN);
            xf = e.v && (e.st != S_RST);
            n_cmp++;
            if (e.cyc != cyc || rd_state !== e.st || rd_valid !== e.v ||
                eng_en !== xe || fifo_en !== xf ||
                fifo_flush !== e.fl || err_clr !== e.fl) begin
                n_bad++;
                $display("FAIL %s cyc %0d: got st=%b v=%b eng=%b fen=%b fl=%b ec=%b exp st=%b v=%b eng=%b fen=%b fl=%b",
                         e.req, cyc, rd_state, rd_valid, eng_en, fifo_en,
                         fifo_flush, err_clr, e.st, e.v, xe, xf, e.fl);
            end
        end
    end

    task automatic push(int c, logic [1:0] st, logic v, logic fl, string r);
        exp_t e;
        e.cyc = c; e.st = st; e.v = v; e.fl = fl; e.req = r;
        q.push_back(e);
    endtask

    // expected trace of a full settling window starting from base cycle b
    task automatic exp_window(int b, logic [1:0] from, logic [1:0] to, string r);
        push(b + 1, from, 1'b0, 1'b0, r);
        push(b + 4, from, 1'b0, 1'b0, r);
        push(b + 5, to, 1'b1, (to == S_RST), r);
        push(b + 6, to, 1'b1, 1'b0, r);
    endtask

    task automatic exp_hold(int b, logic [1:0] st, string r);
        push(b + 1, st, 1'b1, 1'b0, r);
        push(b + 3, st, 1'b1, 1'b0, r);
    endtask

    // driver: apply one stimulus cycle; caller sits at a negedge
    task automatic drive(logic w, logic [2:0] c, logic sw, logic sb, logic er);
        st_wr = w; st_code = c; swrst_wr = sw; swrst_bit = sb; xfer_err = er;
        @(posedge clk);
        #1;
        st_wr = 1'b0; st_code = 3'b000; swrst_wr = 1'b0; swrst_bit = 1'b0; xfer_err = 1'b0;
        @(negedge clk);
    endtask

    task automatic settle(int k);
        repeat (k) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        push(cyc + 1, S_RST, 1'b1, 1'b0, "R1 reset state");
        settle(2);

        // R2 R4 R8: RESET to RUN
        exp_window(cyc, S_RST, S_RUN, "R4 to RUN");
        drive(1, 3'b001, 0, 0, 0); settle(7);

        // R3: out-of-range code ignored
        exp_hold(cyc, S_RUN, "R3 code 5 ignored");
        drive(1, 3'b101, 0, 0, 0); settle(4);

        // R5: exit code in RUN ignored
        exp_hold(cyc, S_RUN, "R5 exit code outside PAUSE");
        drive(1, 3'b010, 0, 0, 0); settle(4);

        // R2 R8: RUN to PAUSE
        exp_window(cyc, S_RUN, S_PAU, "R8 to PAUSE");
        drive(1, 3'b011, 0, 0, 0); settle(7);

        // R5: code 000 in PAUSE ignored
        exp_hold(cyc, S_PAU, "R5 reset code in PAUSE");
        drive(1, 3'b000, 0, 0, 0); settle(4);

        // R5: single exit code only arms
        exp_hold(cyc, S_PAU, "R5 first exit write");
        drive(1, 3'b010, 0, 0, 0); settle(4);

        // R5: PAUSE request cancels the arm
        exp_window(cyc, S_PAU, S_PAU, "R5 cancel via PAUSE");
        drive(1, 3'b011, 0, 0, 0); settle(7);

        exp_hold(cyc, S_PAU, "R5 exit after cancel");
        drive(1, 3'b010, 0, 0, 0); settle(4);

        // R5 R9: second consecutive exit code goes to RESET
        exp_window(cyc, S_PAU, S_RST, "R9 exit to RESET");
        drive(1, 3'b010, 0, 0, 0); settle(7);

        // R3: request during window ignored
        begin
            int b;
            b = cyc;
            push(b + 1, S_RST, 1'b0, 1'b0, "R3 busy write");
            push(b + 4, S_RST, 1'b0, 1'b0, "R3 busy write");
            push(b + 5, S_RUN, 1'b1, 1'b0, "R3 busy write ignored");
            push(b + 8, S_RUN, 1'b1, 1'b0, "R3 busy write ignored");
            drive(1, 3'b001, 0, 0, 0);
            drive(1, 3'b011, 0, 0, 0);
            settle(8);
        end

        // R7: transfer error in RUN
        exp_window(cyc, S_RUN, S_RST, "R7 error in RUN");
        drive(0, 3'b000, 0, 0, 1); settle(7);

        // R7: error in RESET ignored
        exp_hold(cyc, S_RST, "R7 error in RESET");
        drive(0, 3'b000, 0, 0, 1); settle(4);

        // R6: software reset with bit 0 ignored
        exp_window(cyc, S_RST, S_RUN, "R6 prep RUN");
        drive(1, 3'b001, 0, 0, 0); settle(7);
        exp_hold(cyc, S_RUN, "R6 bit zero ignored");
        drive(0, 3'b000, 1, 0, 0); settle(4);

        // R6: software reset wins over a same-cycle request
        exp_window(cyc, S_RUN, S_RST, "R6 swrst priority");
        drive(1, 3'b011, 1, 1, 0); settle(7);

        // R6: software reset inside a window restarts it
        begin
            int b;
            b = cyc;
            push(b + 1, S_RST, 1'b0, 1'b0, "R6 restart");
            exp_window(b + 1, S_RST, S_RST, "R6 restart window");
            drive(1, 3'b001, 0, 0, 0);
            drive(0, 3'b000, 1, 1, 0);
            settle(8);
        end

        // R7: error in PAUSE
        exp_window(cyc, S_RST, S_PAU, "R7 prep PAUSE");
        drive(1, 3'b011, 0, 0, 0); settle(7);
        exp_window(cyc, S_PAU, S_RST, "R7 error in PAUSE");
        drive(0, 3'b000, 0, 0, 1); settle(7);

        settle(2);
        if (q.size() != 0) begin
            n_bad++;
            $display("FAIL R4 unconsumed expectations: got %0d left, exp 0", q.size());
        end
        done_flag = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done_flag) begin
            n_bad++;
            $display("FAIL R1 watchdog expired: got hang, exp completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule